// File: doc/BRIEF.md
# Paged I/O Port Register File

This block is the host-facing register file of a 48-line general-purpose I/O device. A byte-wide synchronous bus with separate read and write strobes reaches a window of 16 byte addresses. Six port registers each own eight lines. A line is driven as an open-drain output with inverted sense: storing 1 in a port bit pulls the line low, and storing 0 lets it float high so that it can serve as an input. Reading a port returns the sampled line in the same inverted sense. The pad itself is modelled as a wired-AND: a line is low when the block pulls it low or when the outside world pulls it low.

Three addresses just above the ports are shared by three register banks. A selector register picks which bank is visible there. The same selector also holds one write-protect bit per port. The polarity and enable banks are held here and exported to a neighbouring edge-detect unit. The event-identification bank lives in that unit: reads of it are forwarded from a side input, and writes to it are sent out as one-cycle strobes with their data. The neighbour's pending summary is readable on every page.

Top module: `ppr_top`

## Requirements
- R1: After reset every port, polarity and enable register is zero, page 0 is selected and no port is write-protected, so every readable address returns 0 while the external lines are released.
- R2: A write to offset 0..5 stores the byte in that port; a 1 bit drives the matching `line_drive_low` bit (port n bit b is line 8n+b) and a 0 bit releases it.
- R3: A read of offset 0..5 returns, per bit, 1 when the line is low (driven low or pulled low by `line_ext_low`) and 0 when it is high.
- R4: A write to offset 7 sets the page from data bits 7:6 and the write-protect mask from bits 5:0 (bit n protects port n); a write to a protected port leaves its register unchanged, while reads of it still return the line state.
- R5: On page 1 a write to offset 8+k (k = 0..2) sets byte k of `edge_pol` (lines 8k..8k+7); on page 2 it sets byte k of `edge_ena`; on page 0 such writes change nothing.
- R6: On page 3 a write to offset 8+k raises bit k of `edge_id_wr` for the cycle of the write strobe with the byte on `edge_id_wdata`, and a read of offset 8+k returns byte k of `edge_id`; no other write raises `edge_id_wr`.
- R7: A read of offset 6 on any page returns `edge_pend` in bits 2:0 and zero in bits 7:3.
- R8: Reads of offset 7, of offsets 8..10 on pages 0, 1 and 2, and of offsets 11..15 return zero.
- R9: Read data appears on `bus_rdata` in the cycle after the read strobe and is zero in any cycle that follows a cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Byte address within the window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| line_ext_low | input | 48 | External pull-down per line, 1 pulls the line low |
| line_drive_low | output | 48 | Per-line pull-low drive from the port registers |
| edge_pol | output | 24 | Polarity bank for the edge-detect unit |
| edge_ena | output | 24 | Enable bank for the edge-detect unit |
| edge_id | input | 24 | Event-identification bits from the edge-detect unit |
| edge_pend | input | 3 | Pending summary from the edge-detect unit |
| edge_id_wr | output | 3 | One-hot write strobe into the identification bank |
| edge_id_wdata | output | 8 | Data for the identification bank write |

## Verification
Each port is written with walking-one bytes and two alternating patterns, first with the external lines released and then with a fixed pull-down pattern, which separates the stored drive from the wired-AND readback and catches swapped ports or bit lanes. All 64 write-protect masks are swept, each followed by a write to every port, which distinguishes a mask applied to the wrong port from one that is ignored. Every page is then selected and every one of the 16 addresses is read with distinct polarity, enable and identification contents, so a bank shown on the wrong page or a leak from a write-only register shows up as a wrong byte. The pending input is swept through all eight values on all pages, and an idle cycle after a read checks that the read data returns to zero.

// File: rtl/ppr_pkg.sv
package ppr_pkg;

    localparam int PORT_W    = 8;   // lines per port register
    localparam int NUM_PORTS = 6;   // port registers at the bottom of the window
    localparam int NUM_PAGED = 3;   // registers behind each shared offset
    localparam int ADDR_W    = 4;   // 16-byte window
    localparam int PAGE_W    = 2;   // page field width in the selector
    localparam int OFS_PEND  = 6;
    localparam int OFS_SEL   = 7;
    localparam int OFS_PAGED = 8;

    typedef enum logic [PAGE_W-1:0] {
        PG_BASE  = 2'd0,
        PG_POL   = 2'd1,
        PG_ENA   = 2'd2,
        PG_IDENT = 2'd3
    } page_e;

endpackage

// File: rtl/ppr_pagelock.sv
module ppr_pagelock
    import ppr_pkg::*;
#(
    parameter int NUM_P  = NUM_PORTS,
    parameter int DATA_W = PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output page_e             page_o,
    output logic [NUM_P-1:0]  lock_o
);

    typedef struct packed {
        page_e             page;
        logic [NUM_P-1:0]  lock;
    } sel_state_t;

    sel_state_t sel_d, sel_q;

    always_comb begin
        sel_d = sel_q;
        if (wr_en) begin
            sel_d.page = page_e'(wdata[DATA_W-1 -: PAGE_W]);
            sel_d.lock = wdata[NUM_P-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '{page: PG_BASE, lock: '0};
        end else begin
            sel_q <= sel_d;
        end
    end

    assign page_o = sel_q.page;
    assign lock_o = sel_q.lock;

    // Selector only changes on a write to its own offset
    assert_sel_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(sel_q));

endmodule

// File: rtl/ppr_port_bank.sv
module ppr_port_bank
    import ppr_pkg::*;
#(
    parameter int NUM_P = NUM_PORTS,
    parameter int PW    = PORT_W,
    localparam int LINES = NUM_P * PW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NUM_P-1:0] wr_sel,
    input  logic [NUM_P-1:0] lock,
    input  logic [PW-1:0]    wdata,
    input  logic [LINES-1:0] ext_low,
    output logic [LINES-1:0] drive_low,
    output logic [LINES-1:0] line_low
);

    typedef struct packed {
        logic [NUM_P-1:0][PW-1:0] port;
    } bank_state_t;

    bank_state_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NUM_P; i++) begin
            if (wr_sel[i] && !lock[i]) begin
                bank_d.port[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign drive_low = bank_q.port;
    // Wired-AND pad: the line is low if either side pulls it down
    assign line_low  = drive_low | ext_low;

    generate
        for (genvar g = 0; g < NUM_P; g++) begin : g_port_chk
            assert_locked_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_sel[g] && lock[g]) |=> $stable(bank_q.port[g]));
            assert_port_written_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_sel[g] && !lock[g]) |=> (drive_low[g*PW +: PW] == $past(wdata)));
        end
    endgenerate

endmodule

// File: rtl/ppr_event_bank.sv
module ppr_event_bank
    import ppr_pkg::*;
#(
    parameter int NUM_B  = NUM_PAGED,
    parameter int BYTE_W = PORT_W,
    localparam int IDX_W = (NUM_B > 1) ? $clog2(NUM_B) : 1,
    localparam int BITS  = NUM_B * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  page_e             page,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BITS-1:0]   pol_o,
    output logic [BITS-1:0]   ena_o,
    output logic [NUM_B-1:0]  id_stb_o,
    output logic [BYTE_W-1:0] id_data_o
);

    typedef struct packed {
        logic [NUM_B-1:0][BYTE_W-1:0] pol;
        logic [NUM_B-1:0][BYTE_W-1:0] ena;
    } evt_state_t;

    evt_state_t evt_d, evt_q;

    always_comb begin
        evt_d    = evt_q;
        id_stb_o = '0;
        for (int k = 0; k < NUM_B; k++) begin
            if (wr_en && idx == IDX_W'(k)) begin
                case (page)
                    PG_POL:   evt_d.pol[k] = wdata;
                    PG_ENA:   evt_d.ena[k] = wdata;
                    PG_IDENT: id_stb_o[k]  = 1'b1;
                    default:  ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q <= '0;
        end else begin
            evt_q <= evt_d;
        end
    end

    assign pol_o     = evt_q.pol;
    assign ena_o     = evt_q.ena;
    assign id_data_o = wdata;

    assert_base_page_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && page == PG_BASE) |=> ($stable(pol_o) && $stable(ena_o)));

    assert_id_strobe_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(id_stb_o));

    assert_id_strobe_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (id_stb_o != '0) |-> (wr_en && page == PG_IDENT));

endmodule

// File: rtl/ppr_top.sv
module ppr_top
    import ppr_pkg::*;
#(
    parameter int NUM_P   = NUM_PORTS,
    parameter int DATA_W  = PORT_W,
    parameter int NUM_B   = NUM_PAGED,
    parameter int AW      = ADDR_W,
    localparam int LINES  = NUM_P * DATA_W,
    localparam int EBITS  = NUM_B * DATA_W,
    localparam int IDX_W  = (NUM_B > 1) ? $clog2(NUM_B) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [LINES-1:0]  line_ext_low,
    output logic [LINES-1:0]  line_drive_low,
    output logic [EBITS-1:0]  edge_pol,
    output logic [EBITS-1:0]  edge_ena,
    input  logic [EBITS-1:0]  edge_id,
    input  logic [NUM_B-1:0]  edge_pend,
    output logic [NUM_B-1:0]  edge_id_wr,
    output logic [DATA_W-1:0] edge_id_wdata
);

    localparam logic [AW-1:0] A_PEND  = AW'(OFS_PEND);
    localparam logic [AW-1:0] A_SEL   = AW'(OFS_SEL);
    localparam logic [AW-1:0] A_PAGED = AW'(OFS_PAGED);
    localparam logic [AW-1:0] A_LAST  = AW'(OFS_PAGED + NUM_B - 1);

    // ---------------- address decode ----------------
    logic [NUM_P-1:0] port_sel;
    logic             paged_hit;
    logic [IDX_W-1:0] paged_idx;
    logic [AW-1:0]    paged_off;

    always_comb begin
        for (int i = 0; i < NUM_P; i++) begin
            port_sel[i] = (bus_addr == AW'(i));
        end
        paged_hit = (bus_addr >= A_PAGED) && (bus_addr <= A_LAST);
        paged_off = bus_addr - A_PAGED;
        paged_idx = paged_off[IDX_W-1:0];
    end

    // ---------------- sub-blocks ----------------
    page_e            page;
    logic [NUM_P-1:0] lock;
    logic [LINES-1:0] line_low;

    ppr_pagelock #(.NUM_P(NUM_P), .DATA_W(DATA_W)) u_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr && bus_addr == A_SEL),
        .wdata  (bus_wdata),
        .page_o (page),
        .lock_o (lock)
    );

    ppr_port_bank #(.NUM_P(NUM_P), .PW(DATA_W)) u_ports (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_sel    (bus_wr ? port_sel : '0),
        .lock      (lock),
        .wdata     (bus_wdata),
        .ext_low   (line_ext_low),
        .drive_low (line_drive_low),
        .line_low  (line_low)
    );

    ppr_event_bank #(.NUM_B(NUM_B), .BYTE_W(DATA_W)) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr && paged_hit),
        .page      (page),
        .idx       (paged_idx),
        .wdata     (bus_wdata),
        .pol_o     (edge_pol),
        .ena_o     (edge_ena),
        .id_stb_o  (edge_id_wr),
        .id_data_o (edge_id_wdata)
    );

    // ---------------- registered read path ----------------
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_state_t;

    rd_state_t        rd_d, rd_q;
    logic [DATA_W-1:0] rd_val;

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NUM_P; i++) begin
            if (port_sel[i]) begin
                rd_val = line_low[i*DATA_W +: DATA_W];
            end
        end
        if (bus_addr == A_PEND) begin
            rd_val[NUM_B-1:0] = edge_pend;
        end
        if (paged_hit && page == PG_IDENT) begin
            for (int k = 0; k < NUM_B; k++) begin
                if (paged_idx == IDX_W'(k)) begin
                    rd_val = edge_id[k*DATA_W +: DATA_W];
                end
            end
        end
        rd_d.rdata = bus_rd ? rd_val : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign bus_rdata = rd_q.rdata;

    assert_rdata_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));

    assert_pend_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_PEND) |=> (bus_rdata[DATA_W-1:NUM_B] == '0));

    assert_pend_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_PEND) |=> (bus_rdata[NUM_B-1:0] == $past(edge_pend)));

    assert_upper_window_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr > A_LAST || bus_addr == A_SEL)) |=> (bus_rdata == '0));

endmodule

// File: tb/ppr_top_tb.sv
module ppr_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [47:0] line_ext_low = '0;
    logic [47:0] line_drive_low;
    logic [23:0] edge_pol;
    logic [23:0] edge_ena;
    logic [23:0] edge_id = '0;
    logic [2:0]  edge_pend = '0;
    logic [2:0]  edge_id_wr;
    logic [7:0]  edge_id_wdata;

    ppr_top dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_addr       (bus_addr),
        .bus_wr         (bus_wr),
        .bus_rd         (bus_rd),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .line_ext_low   (line_ext_low),
        .line_drive_low (line_drive_low),
        .edge_pol       (edge_pol),
        .edge_ena       (edge_ena),
        .edge_id        (edge_id),
        .edge_pend      (edge_pend),
        .edge_id_wr     (edge_id_wr),
        .edge_id_wdata  (edge_id_wdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // bench-side model
    logic [47:0] m_drive = '0;
    logic [23:0] m_pol   = '0;
    logic [23:0] m_ena   = '0;
    logic [1:0]  m_page  = '0;
    logic [5:0]  m_lock  = '0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [3:0] a);
        if (a < 4'd6)  return m_drive[a*8 +: 8] | line_ext_low[a*8 +: 8];
        if (a == 4'd6) return {5'b0, edge_pend};
        if (a >= 4'd8 && a <= 4'd10 && m_page == 2'd3) return edge_id[(a-8)*8 +: 8];
        return 8'h00;
    endfunction

    // write with model update and strobe check (R6)
    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        logic [2:0] exp_stb;
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        #1;
        exp_stb = '0;
        if (a >= 4'd8 && a <= 4'd10 && m_page == 2'd3) exp_stb[a-8] = 1'b1;
        chk("R6 id write strobe", {61'b0, edge_id_wr}, {61'b0, exp_stb});
        if (exp_stb != 0) chk("R6 id write data", {56'b0, edge_id_wdata}, {56'b0, d});
        @(negedge clk);
        bus_wr = 1'b0;
        if (a < 4'd6) begin
            if (!m_lock[a]) m_drive[a*8 +: 8] = d;
        end else if (a == 4'd7) begin
            m_page = d[7:6]; m_lock = d[5:0];
        end else if (a >= 4'd8 && a <= 4'd10) begin
            if (m_page == 2'd1) m_pol[(a-8)*8 +: 8] = d;
            if (m_page == 2'd2) m_ena[(a-8)*8 +: 8] = d;
        end
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic read_chk(input string req, input logic [3:0] a);
        logic [7:0] got;
        logic [7:0] exp;
        exp = exp_read(a);
        bus_read(a, got);
        chk(req, {56'b0, got}, {56'b0, exp});
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] v;
        logic [7:0] got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 drive after reset", {16'b0, line_drive_low}, 64'h0);
        chk("R1 pol after reset", {40'b0, edge_pol}, 64'h0);
        chk("R1 ena after reset", {40'b0, edge_ena}, 64'h0);
        for (int a = 0; a < 16; a++) read_chk("R1 read after reset", 4'(a));

        // R2/R3: port patterns, released then pulled lines
        for (int pass = 0; pass < 2; pass++) begin
            line_ext_low = (pass == 0) ? 48'h0 : 48'h81_0F_F0_3C_00_C3;
            for (int p = 0; p < 6; p++) begin
                for (int k = 0; k < 10; k++) begin
                    v = (k < 8) ? (8'h01 << k) : ((k == 8) ? 8'h5A : 8'hA5);
                    v = v ^ 8'(p * 17);
                    bus_write(4'(p), v);
                    chk("R2 drive_low", {16'b0, line_drive_low}, {16'b0, m_drive});
                    read_chk("R3 port readback", 4'(p));
                end
            end
        end
        line_ext_low = 48'h0;

        // R4: every write-protect mask
        for (int m = 0; m < 64; m++) begin
            bus_write(4'd7, {2'b00, 6'(m)});
            for (int p = 0; p < 6; p++) begin
                bus_write(4'(p), 8'(m * 7 + p * 29 + 1));
                chk("R4 protected write", {16'b0, line_drive_low}, {16'b0, m_drive});
            end
            line_ext_low = {8'(m), 8'h00, 8'(~m), 8'h00, 8'(m), 8'h11};
            for (int p = 0; p < 6; p++) read_chk("R4 protected read", 4'(p));
            line_ext_low = 48'h0;
        end
        bus_write(4'd7, 8'h00);

        // R5/R6/R8: every page, every address
        edge_id = 24'hC3_A5_5A;
        for (int pg = 0; pg < 4; pg++) begin
            bus_write(4'd7, {2'(pg), 6'b0});
            for (int j = 0; j < 3; j++) begin
                bus_write(4'(8 + j), 8'(pg * 48 + j * 5 + 3));
                chk("R5 pol bank", {40'b0, edge_pol}, {40'b0, m_pol});
                chk("R5 ena bank", {40'b0, edge_ena}, {40'b0, m_ena});
            end
            edge_pend = 3'(pg + 2);
            for (int a = 0; a < 16; a++) read_chk("R8 R6 paged window read", 4'(a));
            // R7: pending summary on this page
            for (int pv = 0; pv < 8; pv++) begin
                edge_pend = 3'(pv);
                read_chk("R7 pending read", 4'd6);
            end
        end

        // R9: data valid one cycle after strobe, zero after an idle cycle
        bus_write(4'd7, 8'h00);
        bus_write(4'd2, 8'h9C);
        bus_read(4'd2, got);
        chk("R9 read latency", {56'b0, got}, 64'h9C);
        @(negedge clk);
        chk("R9 idle zero", {56'b0, bus_rdata}, 64'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule